// File: doc/BRIEF.md
# Data MMU Access-Check Pipeline

This block sits between a load/store unit and a data TLB array. Each data access request carries its virtual address, its direction, a context class and a set of space attributes for the address space it names, and the privilege state of the requester. The block checks the request against the privilege rules and the legal virtual range. It then either bypasses translation (hypervisor accesses), asks the external TLB array for a lookup, or faults. The array itself is outside the block: the block drives a lookup address, a context and a real-lookup flag, and takes back a hit flag, a physical page number and three page attributes. Every accepted request ends in exactly one result, either a translation with a cacheable flag or a fault code with fault status.

The control is a three-state machine. ST_IDLE accepts a request and raises `req_ready`. ST_CHECK runs the privilege, alignment and range checks on the captured request. ST_LOOKUP presents the lookup to the TLB array and judges the page attributes. The transitions are: ST_IDLE to ST_CHECK on `req_valid`, ST_CHECK to ST_IDLE when an early fault or a hypervisor bypass settles the result, ST_CHECK to ST_LOOKUP otherwise, and ST_LOOKUP to ST_IDLE always. The result registers load on the edge that leaves ST_CHECK for ST_IDLE, or on the edge that leaves ST_LOOKUP.

Top module: `dmmu_access_check`

## Requirements
- R1: After reset `req_ready` is 1 and `xlat_valid`, `fault_valid` and `tlb_lookup` are 0.
- R2: `req_ready` is high only in the idle state. For a request accepted at edge N, a fault or bypass result is valid after edge N+1, and a looked-up result is valid after edge N+2. `tlb_lookup` is high between N+1 and N+2. A result stays valid for exactly one cycle.
- R3: A non-implicit request made without privilege and without hypervisor privilege, to a space whose user-permitted bit (`req_space_attr[0]`) is clear, faults with code 1. The status class is nucleus (2). This fault outranks the alignment fault.
- R4: A non-implicit request without hypervisor privilege, to a space whose hypervisor-only bit (`req_space_attr[1]`) is set, faults with code 2 and status class nucleus (2). Code 1 wins when both apply. With hypervisor privilege the space is accepted.
- R5: The context class `req_space_cls` selects the lookup context: 0 takes `pri_ctx`, 1 takes `sec_ctx`, 2 takes context 0, and 3 behaves as 0. That class, with 3 reported as 0, is the status class of every later fault.
- R6: A misaligned request faults with code 3 before the range check and without any TLB lookup.
- R7: With `req_addr_mask` set, the address is cut to its low 32 bits before use. Without it, bits [VA_W-1:VA_IMPL_W-1] must be all equal, or the request faults with code 4. The range fault outranks the hypervisor bypass.
- R8: The lookup is real (`tlb_real`=1, `tlb_ctx`=0) when the MMU is off while neither hypervisor nor red state holds, or when the real-space bit (`req_space_attr[2]`) is set.
- R9: With hypervisor privilege, a request that is implicit, or whose space has neither the as-if-user bit (`req_space_attr[3]`) nor the real-space bit, bypasses the TLB. `res_pa` is then the low PA_W bits of the (masked) virtual address and `res_cacheable` is 1.
- R10: A TLB miss faults with code 5, ahead of all page-attribute faults.
- R11: On a hit, the page checks run in this order: a write to a non-writable page gives code 6; a no-fault-only page used by a space without the no-fault bit (`req_space_attr[4]`) gives code 7; a side-effect page used by a no-fault space gives code 8.
- R12: A translated result has `res_pa` = {`tlb_ppn`, VA[PAGE_W-1:0]}. `res_cacheable` is 0 when the page has side effects or bit PA_W-1 of `res_pa` is set, and 1 otherwise.
- R13: In a fault result `xlat_valid` is 0, and `fault_va` and `fault_write` hold the request's virtual address as presented and its direction.
- R14: An implicit request ignores `req_space_cls` and `req_space_attr`. It uses the primary class, skips the R3/R4 checks, and counts as a space with none of the attribute bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_va | input | VA_W | Virtual address |
| req_write | input | 1 | 1 for a store |
| req_space_cls | input | 2 | Context class of the space: 0 primary, 1 secondary, 2 nucleus, 3 other |
| req_space_attr | input | 5 | Space attributes: [0] user-permitted, [1] hypervisor-only, [2] real, [3] as-if-user, [4] no-fault |
| req_priv | input | 1 | Privileged mode |
| req_hpriv | input | 1 | Hypervisor mode |
| req_implicit | input | 1 | Implicit access (no explicit space) |
| req_misaligned | input | 1 | Address not aligned to access size |
| req_addr_mask | input | 1 | 32-bit address masking enabled |
| mmu_en | input | 1 | Data MMU enabled |
| red_state | input | 1 | Reset/error state active |
| pri_ctx | input | CTX_W | Primary context register |
| sec_ctx | input | CTX_W | Secondary context register |
| tlb_lookup | output | 1 | Lookup presented to the TLB array |
| tlb_va | output | VA_W | Lookup address (masked) |
| tlb_ctx | output | CTX_W | Lookup context |
| tlb_real | output | 1 | Real (untranslated-context) lookup |
| tlb_hit | input | 1 | TLB hit |
| tlb_ppn | input | PA_W-PAGE_W | Physical page number of the hit |
| tlb_writable | input | 1 | Page writable |
| tlb_nofault_only | input | 1 | Page for no-fault accesses only |
| tlb_side_effect | input | 1 | Page has side effects |
| xlat_valid | output | 1 | Translation result valid |
| res_pa | output | PA_W | Physical address |
| res_cacheable | output | 1 | Access may be cached |
| fault_valid | output | 1 | Fault result valid |
| fault_code | output | 4 | Fault code (1 to 8) |
| fault_va | output | VA_W | Faulting virtual address |
| fault_ctx_cls | output | 2 | Context class recorded in the status |
| fault_write | output | 1 | Faulting access was a store |

## Verification
The hardest situations to reach are those where several fault conditions hold at once and only the priority order decides the code. Examples are an unprivileged misaligned access to a privileged space, a miss on a page that is also no-fault-only and side-effecting, and a write to a non-writable no-fault page. The stimulus builds each of these by setting every competing condition in one request. For each one it also sets a TLB response that would cause a different fault, so a wrong order shows up as a wrong code. A second hard corner is the hypervisor boundary: bypass, the real-lookup override and the range check all depend on the same privilege bits. Separate requests switch the as-if-user, real, implicit and mask inputs one at a time under hypervisor privilege.

// File: rtl/dmmu_pkg.sv
package dmmu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_LOOKUP = 2'd2
    } dmmu_state_e;

    typedef enum logic [3:0] {
        FC_NONE    = 4'd0,
        FC_PRIV    = 4'd1,
        FC_HVONLY  = 4'd2,
        FC_ALIGN   = 4'd3,
        FC_RANGE   = 4'd4,
        FC_MISS    = 4'd5,
        FC_PROT    = 4'd6,
        FC_NFO     = 4'd7,
        FC_SIDEEFF = 4'd8
    } fault_code_e;

    typedef enum logic [1:0] {
        CC_PRIMARY   = 2'd0,
        CC_SECONDARY = 2'd1,
        CC_NUCLEUS   = 2'd2,
        CC_OTHER     = 2'd3
    } ctx_class_e;

    localparam int SA_USER_OK   = 0;
    localparam int SA_HV_ONLY   = 1;
    localparam int SA_REAL      = 2;
    localparam int SA_ASIF_USER = 3;
    localparam int SA_NOFAULT   = 4;
    localparam int SA_W         = 5;
    localparam int AMASK_W      = 32;

endpackage

// File: rtl/dmmu_space_check.sv
module dmmu_space_check
    import dmmu_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int CTX_W     = 13,
    parameter int VA_IMPL_W = 48
)(
    input  logic [VA_W-1:0]  va,
    input  logic [1:0]       space_cls,
    input  logic [SA_W-1:0]  space_attr,
    input  logic             priv,
    input  logic             hpriv,
    input  logic             implicit,
    input  logic             misaligned,
    input  logic             addr_mask,
    input  logic             mmu_en,
    input  logic             red,
    input  logic [CTX_W-1:0] pri_ctx,
    input  logic [CTX_W-1:0] sec_ctx,
    output logic [3:0]       early_code,
    output logic [1:0]       status_cls,
    output logic [VA_W-1:0]  eff_va,
    output logic [CTX_W-1:0] lookup_ctx,
    output logic             lookup_real,
    output logic             bypass,
    output logic             nofault_space
);

    logic [1:0]      cls_sel;
    logic [SA_W-1:0] attr;
    logic            in_range_raw;
    logic            in_range;

    // Implicit accesses carry no explicit space: attributes read as zero
    assign attr    = implicit ? '0 : space_attr;
    assign cls_sel = (implicit || space_cls == CC_OTHER) ? CC_PRIMARY : space_cls;

    assign eff_va = addr_mask ? {{(VA_W-AMASK_W){1'b0}}, va[AMASK_W-1:0]} : va;

    generate
        if (VA_IMPL_W >= VA_W) begin : g_full_range
            assign in_range_raw = 1'b1;
        end else begin : g_va_hole
            localparam int HI_W = VA_W - VA_IMPL_W + 1;
            logic [HI_W-1:0] hi_bits;
            assign hi_bits      = va[VA_W-1 -: HI_W];
            assign in_range_raw = (&hi_bits) | ~(|hi_bits);
        end
    endgenerate

    assign in_range = addr_mask | in_range_raw;

    // Fixed priority of the checks made before any lookup
    always_comb begin
        early_code = FC_NONE;
        status_cls = cls_sel;
        if (!implicit && !priv && !hpriv && !attr[SA_USER_OK]) begin
            early_code = FC_PRIV;
            status_cls = CC_NUCLEUS;
        end else if (!implicit && !hpriv && attr[SA_HV_ONLY]) begin
            early_code = FC_HVONLY;
            status_cls = CC_NUCLEUS;
        end else if (misaligned) begin
            early_code = FC_ALIGN;
        end else if (!in_range) begin
            early_code = FC_RANGE;
        end
    end

    assign lookup_real   = (!mmu_en && !hpriv && !red) || attr[SA_REAL];
    assign bypass        = hpriv && (implicit || (!attr[SA_ASIF_USER] && !attr[SA_REAL]));
    assign nofault_space = attr[SA_NOFAULT];

    always_comb begin
        if (lookup_real || cls_sel == CC_NUCLEUS) begin
            lookup_ctx = '0;
        end else if (cls_sel == CC_SECONDARY) begin
            lookup_ctx = sec_ctx;
        end else begin
            lookup_ctx = pri_ctx;
        end
    end

endmodule

// File: rtl/dmmu_attr_check.sv
module dmmu_attr_check
    import dmmu_pkg::*;
#(
    parameter int PA_W   = 40,
    parameter int PAGE_W = 13
)(
    input  logic                   hit,
    input  logic                   write,
    input  logic                   nofault_space,
    input  logic                   pg_writable,
    input  logic                   pg_nofault_only,
    input  logic                   pg_side_effect,
    input  logic [PA_W-PAGE_W-1:0] ppn,
    input  logic [PAGE_W-1:0]      offset,
    output logic [3:0]             late_code,
    output logic [PA_W-1:0]        pa,
    output logic                   cacheable
);

    assign pa        = {ppn, offset};
    assign cacheable = !(pg_side_effect || pa[PA_W-1]);

    always_comb begin
        late_code = FC_NONE;
        if (!hit) begin
            late_code = FC_MISS;
        end else if (write && !pg_writable) begin
            late_code = FC_PROT;
        end else if (pg_nofault_only && !nofault_space) begin
            late_code = FC_NFO;
        end else if (pg_side_effect && nofault_space) begin
            late_code = FC_SIDEEFF;
        end
    end

endmodule

// File: rtl/dmmu_access_check.sv
module dmmu_access_check
    import dmmu_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PA_W      = 40,
    parameter int PAGE_W    = 13,
    parameter int CTX_W     = 13,
    parameter int VA_IMPL_W = 48
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VA_W-1:0]        req_va,
    input  logic                   req_write,
    input  logic [1:0]             req_space_cls,
    input  logic [4:0]             req_space_attr,
    input  logic                   req_priv,
    input  logic                   req_hpriv,
    input  logic                   req_implicit,
    input  logic                   req_misaligned,
    input  logic                   req_addr_mask,
    input  logic                   mmu_en,
    input  logic                   red_state,
    input  logic [CTX_W-1:0]       pri_ctx,
    input  logic [CTX_W-1:0]       sec_ctx,
    output logic                   tlb_lookup,
    output logic [VA_W-1:0]        tlb_va,
    output logic [CTX_W-1:0]       tlb_ctx,
    output logic                   tlb_real,
    input  logic                   tlb_hit,
    input  logic [PA_W-PAGE_W-1:0] tlb_ppn,
    input  logic                   tlb_writable,
    input  logic                   tlb_nofault_only,
    input  logic                   tlb_side_effect,
    output logic                   xlat_valid,
    output logic [PA_W-1:0]        res_pa,
    output logic                   res_cacheable,
    output logic                   fault_valid,
    output logic [3:0]             fault_code,
    output logic [VA_W-1:0]        fault_va,
    output logic [1:0]             fault_ctx_cls,
    output logic                   fault_write
);

    dmmu_state_e state_q, state_d;

    // Captured request
    logic [VA_W-1:0]  rq_va;
    logic             rq_write, rq_priv, rq_hpriv, rq_impl, rq_mis, rq_amask, rq_mmu_en, rq_red;
    logic [1:0]       rq_cls;
    logic [SA_W-1:0]  rq_attr;
    logic [CTX_W-1:0] rq_pri, rq_sec;

    // Check results
    logic [3:0]       early_code, late_code;
    logic [1:0]       status_cls;
    logic [VA_W-1:0]  eff_va;
    logic [CTX_W-1:0] lookup_ctx;
    logic             lookup_real, bypass, nofault_space, early_fault, late_fault;
    logic [PA_W-1:0]  lk_pa;
    logic             lk_cacheable;

    // Result registers
    logic             res_vld_q, fault_q, cache_q, wr_q;
    logic [3:0]       code_q;
    logic [1:0]       cls_q;
    logic [VA_W-1:0]  va_q;
    logic [PA_W-1:0]  pa_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_va <= '0; rq_write <= 1'b0; rq_priv <= 1'b0; rq_hpriv <= 1'b0;
            rq_impl <= 1'b0; rq_mis <= 1'b0; rq_amask <= 1'b0; rq_mmu_en <= 1'b0;
            rq_red <= 1'b0; rq_cls <= '0; rq_attr <= '0; rq_pri <= '0; rq_sec <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            rq_va <= req_va; rq_write <= req_write; rq_priv <= req_priv;
            rq_hpriv <= req_hpriv; rq_impl <= req_implicit; rq_mis <= req_misaligned;
            rq_amask <= req_addr_mask; rq_mmu_en <= mmu_en; rq_red <= red_state;
            rq_cls <= req_space_cls; rq_attr <= req_space_attr;
            rq_pri <= pri_ctx; rq_sec <= sec_ctx;
        end
    end

    dmmu_space_check #(
        .VA_W      (VA_W),
        .CTX_W     (CTX_W),
        .VA_IMPL_W (VA_IMPL_W)
    ) u_space (
        .va            (rq_va),
        .space_cls     (rq_cls),
        .space_attr    (rq_attr),
        .priv          (rq_priv),
        .hpriv         (rq_hpriv),
        .implicit      (rq_impl),
        .misaligned    (rq_mis),
        .addr_mask     (rq_amask),
        .mmu_en        (rq_mmu_en),
        .red           (rq_red),
        .pri_ctx       (rq_pri),
        .sec_ctx       (rq_sec),
        .early_code    (early_code),
        .status_cls    (status_cls),
        .eff_va        (eff_va),
        .lookup_ctx    (lookup_ctx),
        .lookup_real   (lookup_real),
        .bypass        (bypass),
        .nofault_space (nofault_space)
    );

    dmmu_attr_check #(
        .PA_W   (PA_W),
        .PAGE_W (PAGE_W)
    ) u_attr (
        .hit             (tlb_hit),
        .write           (rq_write),
        .nofault_space   (nofault_space),
        .pg_writable     (tlb_writable),
        .pg_nofault_only (tlb_nofault_only),
        .pg_side_effect  (tlb_side_effect),
        .ppn             (tlb_ppn),
        .offset          (eff_va[PAGE_W-1:0]),
        .late_code       (late_code),
        .pa              (lk_pa),
        .cacheable       (lk_cacheable)
    );

    assign early_fault = (early_code != FC_NONE);
    assign late_fault  = (late_code != FC_NONE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_CHECK;
            ST_CHECK:  state_d = (early_fault || bypass) ? ST_IDLE : ST_LOOKUP;
            ST_LOOKUP: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_vld_q <= 1'b0; fault_q <= 1'b0; cache_q <= 1'b0; wr_q <= 1'b0;
            code_q <= '0; cls_q <= '0; va_q <= '0; pa_q <= '0;
        end else begin
            res_vld_q <= 1'b0;
            if (state_q == ST_CHECK && (early_fault || bypass)) begin
                res_vld_q <= 1'b1;
                fault_q   <= early_fault;
                code_q    <= early_code;
                cls_q     <= status_cls;
                va_q      <= rq_va;
                wr_q      <= rq_write;
                pa_q      <= early_fault ? '0 : eff_va[PA_W-1:0];
                cache_q   <= !early_fault;
            end else if (state_q == ST_LOOKUP) begin
                res_vld_q <= 1'b1;
                fault_q   <= late_fault;
                code_q    <= late_code;
                cls_q     <= status_cls;
                va_q      <= rq_va;
                wr_q      <= rq_write;
                pa_q      <= late_fault ? '0 : lk_pa;
                cache_q   <= !late_fault && lk_cacheable;
            end
        end
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign tlb_lookup    = (state_q == ST_LOOKUP);
    assign tlb_va        = eff_va;
    assign tlb_ctx       = lookup_ctx;
    assign tlb_real      = lookup_real;
    assign xlat_valid    = res_vld_q && !fault_q;
    assign fault_valid   = res_vld_q && fault_q;
    assign res_pa        = pa_q;
    assign res_cacheable = cache_q;
    assign fault_code    = code_q;
    assign fault_va      = va_q;
    assign fault_ctx_cls = cls_q;
    assign fault_write   = wr_q;

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_valid || fault_valid) |=> !(xlat_valid || fault_valid));  // R2
    AST_LOOKUP_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_lookup |=> (xlat_valid || fault_valid));  // R2
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);  // R2
    AST_REAL_CTX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_lookup && tlb_real) |-> (tlb_ctx == '0));  // R8
    AST_MISS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_lookup && !tlb_hit) |=> (fault_valid && fault_code == FC_MISS));  // R10
    AST_SIDE_EFFECT_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_lookup && tlb_hit && tlb_side_effect) |=> (!xlat_valid || !res_cacheable));  // R12
    AST_FAULT_CODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_code != FC_NONE));  // R13

endmodule

// File: tb/dmmu_access_check_tb.sv
`timescale 1ns/1ps
module dmmu_access_check_tb;

    localparam int VA_W = 64;
    localparam int PA_W = 40;
    localparam int PAGE_W = 13;
    localparam int CTX_W = 13;
    localparam int PPN_W = PA_W - PAGE_W;
    localparam logic [CTX_W-1:0] PRI = 13'h0123;
    localparam logic [CTX_W-1:0] SEC = 13'h0456;

    typedef struct {
        logic [VA_W-1:0]  va;
        logic             write;
        logic [1:0]       cls;
        logic [4:0]       attr;
        logic             priv, hpriv, impl, mis, amask, mmu, red;
        logic             hit;
        logic [PPN_W-1:0] ppn;
        logic             wr, nfo, se;
    } req_t;

    typedef struct {
        string            name;
        logic             has_lk;
        logic [VA_W-1:0]  lk_va;
        logic [CTX_W-1:0] lk_ctx;
        logic             lk_real;
        logic             fault;
        logic [3:0]       code;
        logic [1:0]       cls;
        logic [VA_W-1:0]  fva;
        logic             fwr;
        logic [PA_W-1:0]  pa;
        logic             cache;
        int               lat;
        int               acc;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [VA_W-1:0] req_va = '0;
    logic req_write = 1'b0;
    logic [1:0] req_space_cls = '0;
    logic [4:0] req_space_attr = '0;
    logic req_priv = 1'b0, req_hpriv = 1'b0, req_implicit = 1'b0, req_misaligned = 1'b0;
    logic req_addr_mask = 1'b0, mmu_en = 1'b0, red_state = 1'b0;
    logic tlb_lookup, tlb_real;
    logic [VA_W-1:0] tlb_va;
    logic [CTX_W-1:0] tlb_ctx;
    logic tlb_hit = 1'b0, tlb_writable = 1'b0, tlb_nofault_only = 1'b0, tlb_side_effect = 1'b0;
    logic [PPN_W-1:0] tlb_ppn = '0;
    logic xlat_valid, res_cacheable, fault_valid, fault_write;
    logic [PA_W-1:0] res_pa;
    logic [3:0] fault_code;
    logic [VA_W-1:0] fault_va;
    logic [1:0] fault_ctx_cls;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit lk_seen = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dmmu_access_check #(
        .VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .CTX_W(CTX_W), .VA_IMPL_W(48)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_write(req_write), .req_space_cls(req_space_cls),
        .req_space_attr(req_space_attr), .req_priv(req_priv), .req_hpriv(req_hpriv),
        .req_implicit(req_implicit), .req_misaligned(req_misaligned),
        .req_addr_mask(req_addr_mask), .mmu_en(mmu_en), .red_state(red_state),
        .pri_ctx(PRI), .sec_ctx(SEC), .tlb_lookup(tlb_lookup), .tlb_va(tlb_va),
        .tlb_ctx(tlb_ctx), .tlb_real(tlb_real), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
        .tlb_writable(tlb_writable), .tlb_nofault_only(tlb_nofault_only),
        .tlb_side_effect(tlb_side_effect), .xlat_valid(xlat_valid), .res_pa(res_pa),
        .res_cacheable(res_cacheable), .fault_valid(fault_valid), .fault_code(fault_code),
        .fault_va(fault_va), .fault_ctx_cls(fault_ctx_cls), .fault_write(fault_write)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic req_t base();
        req_t t;
        t.va = 64'h0000_0000_1234_5678; t.write = 1'b0; t.cls = 2'd0; t.attr = 5'b00001;
        t.priv = 1'b1; t.hpriv = 1'b0; t.impl = 1'b0; t.mis = 1'b0; t.amask = 1'b0;
        t.mmu = 1'b1; t.red = 1'b0; t.hit = 1'b1; t.ppn = 27'h2ABCDEF;
        t.wr = 1'b1; t.nfo = 1'b0; t.se = 1'b0;
        return t;
    endfunction

    function automatic logic [VA_W-1:0] lkva(input req_t t);
        return t.amask ? {32'h0, t.va[31:0]} : t.va;
    endfunction

    task automatic issue(input req_t t, input exp_t e);
        while (!req_ready) @(negedge clk);
        req_va = t.va; req_write = t.write; req_space_cls = t.cls; req_space_attr = t.attr;
        req_priv = t.priv; req_hpriv = t.hpriv; req_implicit = t.impl;
        req_misaligned = t.mis; req_addr_mask = t.amask; mmu_en = t.mmu; red_state = t.red;
        tlb_hit = t.hit; tlb_ppn = t.ppn; tlb_writable = t.wr;
        tlb_nofault_only = t.nfo; tlb_side_effect = t.se;
        e.acc = cyc + 1;
        q.push_back(e);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic go_ok(input req_t t, input logic [CTX_W-1:0] ctx, input logic rl,
                         input logic cache, input string nm);
        exp_t e;
        e.name = nm; e.has_lk = 1'b1; e.lk_va = lkva(t); e.lk_ctx = ctx; e.lk_real = rl;
        e.fault = 1'b0; e.code = 4'd0; e.cls = 2'd0; e.fva = t.va; e.fwr = t.write;
        e.pa = {t.ppn, e.lk_va[PAGE_W-1:0]}; e.cache = cache; e.lat = 2; e.acc = 0;
        issue(t, e);
    endtask

    task automatic go_fault(input req_t t, input logic has_lk, input logic [CTX_W-1:0] ctx,
                            input logic rl, input logic [3:0] code, input logic [1:0] cls,
                            input string nm);
        exp_t e;
        e.name = nm; e.has_lk = has_lk; e.lk_va = lkva(t); e.lk_ctx = ctx; e.lk_real = rl;
        e.fault = 1'b1; e.code = code; e.cls = cls; e.fva = t.va; e.fwr = t.write;
        e.pa = '0; e.cache = 1'b0; e.lat = has_lk ? 2 : 1; e.acc = 0;
        issue(t, e);
    endtask

    task automatic go_bypass(input req_t t, input logic [PA_W-1:0] pa, input string nm);
        exp_t e;
        e.name = nm; e.has_lk = 1'b0; e.lk_va = '0; e.lk_ctx = '0; e.lk_real = 1'b0;
        e.fault = 1'b0; e.code = 4'd0; e.cls = 2'd0; e.fva = t.va; e.fwr = t.write;
        e.pa = pa; e.cache = 1'b1; e.lat = 1; e.acc = 0;
        issue(t, e);
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tlb_lookup) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected lookup", 64'd1, 64'd0);
                end else begin
                    chk(q[0].has_lk, q[0].name, "lookup issued", 64'd1, 64'(q[0].has_lk));
                    chk(tlb_va == q[0].lk_va, q[0].name, "tlb_va", tlb_va, q[0].lk_va);
                    chk(tlb_ctx == q[0].lk_ctx, q[0].name, "tlb_ctx", 64'(tlb_ctx), 64'(q[0].lk_ctx));
                    chk(tlb_real == q[0].lk_real, q[0].name, "tlb_real", 64'(tlb_real), 64'(q[0].lk_real));
                    lk_seen = 1'b1;
                end
            end
            if (rst_n && (xlat_valid || fault_valid)) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected result", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk((cyc - e.acc) == e.lat, {e.name, " R2"}, "latency",
                        64'(cyc - e.acc), 64'(e.lat));
                    chk(lk_seen == e.has_lk, {e.name, " R6"}, "lookup seen",
                        64'(lk_seen), 64'(e.has_lk));
                    lk_seen = 1'b0;
                    if (e.fault) begin
                        chk(fault_valid && !xlat_valid, {e.name, " R13"}, "fault/xlat flags",
                            {62'd0, fault_valid, xlat_valid}, 64'd2);
                        chk(fault_code == e.code, e.name, "fault_code", 64'(fault_code), 64'(e.code));
                        chk(fault_ctx_cls == e.cls, e.name, "fault_ctx_cls",
                            64'(fault_ctx_cls), 64'(e.cls));
                        chk(fault_va == e.fva, {e.name, " R13"}, "fault_va", fault_va, e.fva);
                        chk(fault_write == e.fwr, {e.name, " R13"}, "fault_write",
                            64'(fault_write), 64'(e.fwr));
                    end else begin
                        chk(xlat_valid && !fault_valid, e.name, "xlat/fault flags",
                            {62'd0, xlat_valid, fault_valid}, 64'd2);
                        chk(res_pa == e.pa, e.name, "res_pa", 64'(res_pa), 64'(e.pa));
                        chk(res_cacheable == e.cache, e.name, "res_cacheable",
                            64'(res_cacheable), 64'(e.cache));
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Driver
    initial begin
        req_t t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
        chk(!xlat_valid && !fault_valid, "R1", "result flags after reset",
            {62'd0, xlat_valid, fault_valid}, 64'd0);
        chk(tlb_lookup == 1'b0, "R1", "tlb_lookup after reset", 64'(tlb_lookup), 64'd0);

        // R5 context classes
        t = base();                       go_ok(t, PRI, 1'b0, 1'b1, "R5 primary");
        t = base(); t.cls = 2'd1;         go_ok(t, SEC, 1'b0, 1'b1, "R5 secondary");
        t = base(); t.cls = 2'd2;         go_ok(t, '0,  1'b0, 1'b1, "R5 nucleus");
        t = base(); t.cls = 2'd3;         go_ok(t, PRI, 1'b0, 1'b1, "R5 other");

        // R3 privileged-only space
        t = base(); t.priv = 1'b0; t.attr = 5'b00000; t.cls = 2'd1; t.mis = 1'b1; t.write = 1'b1;
        go_fault(t, 1'b0, '0, 1'b0, 4'd1, 2'd2, "R3 priv space unprivileged");
        t = base(); t.priv = 1'b0;        go_ok(t, PRI, 1'b0, 1'b1, "R3 user space unprivileged");

        // R4 hypervisor-only space
        t = base(); t.attr = 5'b00011;
        go_fault(t, 1'b0, '0, 1'b0, 4'd2, 2'd2, "R4 hv space without hv");
        t = base(); t.priv = 1'b0; t.attr = 5'b00010;
        go_fault(t, 1'b0, '0, 1'b0, 4'd1, 2'd2, "R4 priority priv over hv");
        t = base(); t.hpriv = 1'b1; t.attr = 5'b01010;
        go_ok(t, PRI, 1'b0, 1'b1, "R4 hv space with hv");

        // R6 alignment before range
        t = base(); t.mis = 1'b1; t.cls = 2'd1; t.va = 64'h0001_0000_0000_0000;
        go_fault(t, 1'b0, '0, 1'b0, 4'd3, 2'd1, "R6 misaligned");

        // R7 range and masking
        t = base(); t.va = 64'h0001_0000_0000_0000;
        go_fault(t, 1'b0, '0, 1'b0, 4'd4, 2'd0, "R7 va hole");
        t = base(); t.va = 64'hFFFF_8000_0000_2000;
        go_ok(t, PRI, 1'b0, 1'b1, "R7 sign extended va");
        t = base(); t.va = 64'h1234_5678_9ABC_DEF0; t.amask = 1'b1;
        go_ok(t, PRI, 1'b0, 1'b1, "R7 address mask");
        t = base(); t.va = 64'h0001_0000_0000_0000; t.hpriv = 1'b1;
        go_fault(t, 1'b0, '0, 1'b0, 4'd4, 2'd0, "R7 range before bypass");

        // R8 real lookups
        t = base(); t.mmu = 1'b0;         go_ok(t, '0,  1'b1, 1'b1, "R8 mmu off");
        t = base(); t.mmu = 1'b0; t.red = 1'b1;
        go_ok(t, PRI, 1'b0, 1'b1, "R8 mmu off red");
        t = base(); t.mmu = 1'b0; t.hpriv = 1'b1; t.attr = 5'b01001;
        go_ok(t, PRI, 1'b0, 1'b1, "R8 mmu off hv as-if-user");
        t = base(); t.attr = 5'b00101; t.cls = 2'd1;
        go_ok(t, '0,  1'b1, 1'b1, "R8 real space");

        // R9 hypervisor bypass
        t = base(); t.hpriv = 1'b1; t.va = 64'h0000_0080_0000_1000;
        go_bypass(t, 40'h80_0000_1000, "R9 bypass");
        t = base(); t.hpriv = 1'b1; t.impl = 1'b1; t.attr = 5'b01001;
        go_bypass(t, 40'h00_1234_5678, "R9 implicit bypass");
        t = base(); t.hpriv = 1'b1; t.amask = 1'b1; t.va = 64'hABCD_0000_8765_4321;
        go_bypass(t, 40'h00_8765_4321, "R9 masked bypass");

        // R10 miss outranks page faults
        t = base(); t.hit = 1'b0; t.write = 1'b1; t.wr = 1'b0; t.nfo = 1'b1; t.se = 1'b1;
        go_fault(t, 1'b1, PRI, 1'b0, 4'd5, 2'd0, "R10 miss");

        // R11 page attribute priority
        t = base(); t.write = 1'b1; t.wr = 1'b0;
        go_fault(t, 1'b1, PRI, 1'b0, 4'd6, 2'd0, "R11 protection");
        t = base(); t.write = 1'b1; t.wr = 1'b0; t.nfo = 1'b1;
        go_fault(t, 1'b1, PRI, 1'b0, 4'd6, 2'd0, "R11 protection over nfo");
        t = base(); t.nfo = 1'b1;
        go_fault(t, 1'b1, PRI, 1'b0, 4'd7, 2'd0, "R11 nfo normal space");
        t = base(); t.nfo = 1'b1; t.attr = 5'b10001;
        go_ok(t, PRI, 1'b0, 1'b1, "R11 nfo with nofault space");
        t = base(); t.se = 1'b1; t.attr = 5'b10001; t.cls = 2'd1;
        go_fault(t, 1'b1, SEC, 1'b0, 4'd8, 2'd1, "R11 side effect nofault space");
        t = base(); t.se = 1'b1; t.nfo = 1'b1;
        go_fault(t, 1'b1, PRI, 1'b0, 4'd7, 2'd0, "R11 nfo over side effect");

        // R12 cacheability
        t = base(); t.write = 1'b1; t.se = 1'b1;
        go_ok(t, PRI, 1'b0, 1'b0, "R12 side effect uncached");
        t = base(); t.ppn = 27'h4000123;
        go_ok(t, PRI, 1'b0, 1'b0, "R12 pa top bit uncached");

        // R14 implicit accesses
        t = base(); t.impl = 1'b1; t.priv = 1'b0; t.attr = 5'b00010; t.cls = 2'd1;
        go_ok(t, PRI, 1'b0, 1'b1, "R14 implicit ignores space");
        t = base(); t.impl = 1'b1; t.attr = 5'b10000; t.nfo = 1'b1;
        go_fault(t, 1'b1, PRI, 1'b0, 4'd7, 2'd0, "R14 implicit not nofault");
        t = base(); t.impl = 1'b1; t.attr = 5'b00100;
        go_ok(t, PRI, 1'b0, 1'b1, "R14 implicit not real");

        for (int i = 0; i < 50 && q.size() != 0; i++) @(negedge clk);
        chk(q.size() == 0, "R2", "all results returned", 64'(q.size()), 64'd0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule